// File: doc/BRIEF.md
# Memory Test Failure Summary Logger

This block sits beside a memory test engine and turns its stream of compare results into a running summary of failures. Each cycle the engine may present one compare event. An event carries a test number, a word address, the word that was expected and the word that was read back. A compare fails when the two words differ. The set of differing bits is the failure's error pattern.

From the failures the block keeps the following registers, all readable at its outputs:
- the span of failing addresses,
- a sticky mask of every bit that has ever failed,
- the total, smallest and largest number of failing bits per failure,
- the number of failures,
- the longest stretch of failures at back-to-back word addresses,
- an error count for each test number,
- a record of the most recent distinct failure, with a repeat count.

Software can form the average number of failing bits per failure by dividing the bit total by the failure count. A synchronous clear input wipes the whole summary when a new test campaign starts.

Top module: `mem_err_logger`

## Requirements
- R1: The error pattern of a compare is `cmp_exp ^ cmp_got`. A compare whose pattern is zero is not a failure, and it changes no summary register.
- R2: `addr_lo`/`addr_hi` hold the smallest and largest failing address. After reset or clear they read all ones and zero, so the first failure sets both.
- R3: `bit_mask` is the OR of the error patterns of all failures since the last clear.
- R4: `bits_total` is the sum of the population counts of all error patterns. `bits_min`/`bits_max` hold the smallest and largest single population count, and read all ones and zero after reset or clear.
- R5: `fail_count` counts failures since the last clear.
- R6: A failure at exactly the previous failure's address plus one extends the current run. Any other failure starts a run of length 1. A passing compare ends the run, and cycles with `cmp_valid` low leave it untouched. `run_max` holds the longest run.
- R7: Each test number t has its own failure counter at `test_counts[t*CNT_W +: CNT_W]`.
- R8: A failure with the same address and error pattern as the current record increments `last_repeat`. Any other failure replaces `last_test`, `last_addr` and `last_bits` and sets `last_repeat` to 1. All record fields read zero after reset or clear.
- R9: `clr` is synchronous and takes priority over a compare in the same cycle. That compare is discarded, and every register returns to its reset value.
- R10: The outputs are registered. A compare is visible after the next rising clock edge, and cycles with `cmp_valid` low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of all statistics |
| cmp_valid | input | 1 | A compare event is present |
| cmp_test | input | TEST_W | Test number of the event |
| cmp_addr | input | ADDR_W | Word address of the event |
| cmp_exp | input | DATA_W | Expected word |
| cmp_got | input | DATA_W | Word read back |
| fail_count | output | CNT_W | Number of failures |
| addr_lo | output | ADDR_W | Lowest failing address |
| addr_hi | output | ADDR_W | Highest failing address |
| bit_mask | output | DATA_W | Sticky failing-bit mask |
| bits_total | output | CNT_W+BC_W | Sum of failing bits |
| bits_min | output | BC_W | Fewest failing bits in one failure |
| bits_max | output | BC_W | Most failing bits in one failure |
| run_max | output | CNT_W | Longest run of consecutive failing addresses |
| test_counts | output | NUM_TESTS*CNT_W | Per-test failure counters, test t at slice t |
| last_test | output | TEST_W | Test number of the current record |
| last_addr | output | ADDR_W | Address of the current record |
| last_bits | output | DATA_W | Error pattern of the current record |
| last_repeat | output | CNT_W | Occurrences of the current record |

## Verification
The bench covers the following cases, each tied to a specific wrong design:
- A passing compare between two adjacent failures must break the run. An idle cycle in the same place must not. A tracker that confuses the two reports the wrong run length.
- Repeating a failure at the same address is not adjacency. A design that treats it as adjacency lengthens the run.
- A failure at the same address but with a different error pattern must open a new record. Keying the record on the address alone would only bump the repeat count.
- A clear arriving in the same cycle as a failure must win. If it did not, one failure would leak into the fresh summary.
- The first failure after a clear must set both address bounds. With the wrong initial values one bound stays stale.
- A failure with every bit flipped checks the full-width population count.

// File: rtl/mel_pkg.sv
// Shared declarations for the memory test failure logger.
// Assumes nothing beyond IEEE 1800-2017 packages.
package mel_pkg;

    // Action the run tracker takes for one cycle's compare.
    typedef enum logic [1:0] {
        RUN_HOLD   = 2'd0,   // no compare this cycle
        RUN_BREAK  = 2'd1,   // passing compare ends the run
        RUN_START  = 2'd2,   // failure opens a new run
        RUN_EXTEND = 2'd3    // failure at previous address + 1
    } run_act_e;

endpackage

// File: rtl/mel_popcount.sv
// Population count of an error pattern, purely combinational.
// Assumes CNT_W is wide enough to hold DATA_W.
module mel_popcount #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] bits,
    output logic [CNT_W-1:0]  ones
);

    // Sum every bit of the pattern.
    always_comb begin
        ones = '0;
        for (int i = 0; i < DATA_W; i++) begin
            ones = ones + CNT_W'(bits[i]);
        end
    end

endmodule

// File: rtl/mel_run_track.sv
// Tracks runs of failures at consecutive word addresses and keeps the
// longest one. Assumes fail is only high together with cmp_valid.
module mel_run_track #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cmp_valid,
    input  logic              fail,
    input  logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  run_max
);
    import mel_pkg::*;

    logic [CNT_W-1:0]  run_cur;
    logic [CNT_W-1:0]  run_next;
    logic [ADDR_W-1:0] prev_addr;
    run_act_e          act;

    // Classify this cycle's compare.
    always_comb begin
        if (!cmp_valid)
            act = RUN_HOLD;
        else if (!fail)
            act = RUN_BREAK;
        else if ((run_cur != '0) && (addr == ADDR_W'(prev_addr + 1'b1)))
            act = RUN_EXTEND;
        else
            act = RUN_START;
    end

    // Next length of the current run.
    always_comb begin
        case (act)
            RUN_BREAK:  run_next = '0;
            RUN_START:  run_next = CNT_W'(1);
            RUN_EXTEND: run_next = run_cur + 1'b1;
            default:    run_next = run_cur;
        endcase
    end

    // Hold the current run, last failing address and longest run.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_cur   <= '0;
            prev_addr <= '0;
            run_max   <= '0;
        end else begin
            run_cur <= run_next;
            if (act == RUN_START || act == RUN_EXTEND)
                prev_addr <= addr;
            if (run_next > run_max)
                run_max <= run_next;
        end
    end

endmodule

// File: rtl/mel_record.sv
// Keeps the most recent distinct failure and how often it repeated.
// A record is the same when address and error pattern both match.
module mel_record #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TEST_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fail,
    input  logic [TEST_W-1:0] test,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] err_bits,
    output logic [TEST_W-1:0] last_test,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_bits,
    output logic [CNT_W-1:0]  last_repeat
);

    logic same;

    // Match against the held record; an empty record never matches.
    always_comb begin
        same = (last_repeat != '0) && (addr == last_addr) && (err_bits == last_bits);
    end

    // Update or replace the record on each failure.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            last_test   <= '0;
            last_addr   <= '0;
            last_bits   <= '0;
            last_repeat <= '0;
        end else if (fail) begin
            if (same) begin
                last_repeat <= last_repeat + 1'b1;
            end else begin
                last_test   <= test;
                last_addr   <= addr;
                last_bits   <= err_bits;
                last_repeat <= CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/mel_test_counters.sv
// One failure counter per test number, packed into a flat bus.
// Assumes test numbers span the full TEST_W range.
module mel_test_counters #(
    parameter int TEST_W = 4,
    parameter int CNT_W  = 16,
    localparam int NUM_TESTS = 1 << TEST_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       fail,
    input  logic [TEST_W-1:0]          test,
    output logic [NUM_TESTS*CNT_W-1:0] counts
);

    for (genvar t = 0; t < NUM_TESTS; t++) begin : g_test
        logic [CNT_W-1:0] cnt;

        // Count failures belonging to test t.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                cnt <= '0;
            else if (fail && (test == TEST_W'(t)))
                cnt <= cnt + 1'b1;
        end

        assign counts[t*CNT_W +: CNT_W] = cnt;
    end

endmodule

// File: rtl/mem_err_logger.sv
// Memory test failure summary logger. Reduces a stream of compare events
// to address span, sticky bit mask, bit-count statistics, run length,
// per-test counts and a de-duplicated last-failure record.
// Assumes at most one compare per cycle; clr overrides a same-cycle compare.
module mem_err_logger #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TEST_W = 4,
    parameter int CNT_W  = 16,
    localparam int NUM_TESTS = 1 << TEST_W,
    localparam int BC_W      = $clog2(DATA_W + 1),
    localparam int TOT_W     = CNT_W + BC_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       cmp_valid,
    input  logic [TEST_W-1:0]          cmp_test,
    input  logic [ADDR_W-1:0]          cmp_addr,
    input  logic [DATA_W-1:0]          cmp_exp,
    input  logic [DATA_W-1:0]          cmp_got,
    output logic [CNT_W-1:0]           fail_count,
    output logic [ADDR_W-1:0]          addr_lo,
    output logic [ADDR_W-1:0]          addr_hi,
    output logic [DATA_W-1:0]          bit_mask,
    output logic [TOT_W-1:0]           bits_total,
    output logic [BC_W-1:0]            bits_min,
    output logic [BC_W-1:0]            bits_max,
    output logic [CNT_W-1:0]           run_max,
    output logic [NUM_TESTS*CNT_W-1:0] test_counts,
    output logic [TEST_W-1:0]          last_test,
    output logic [ADDR_W-1:0]          last_addr,
    output logic [DATA_W-1:0]          last_bits,
    output logic [CNT_W-1:0]           last_repeat
);

    logic [DATA_W-1:0] err_bits;
    logic              fail;
    logic              fail_live;
    logic [BC_W-1:0]   nbits;

    // Error pattern and failure qualification.
    always_comb begin
        err_bits  = cmp_exp ^ cmp_got;
        fail      = cmp_valid && (err_bits != '0);
        fail_live = fail && !clr;
    end

    mel_popcount #(.DATA_W(DATA_W), .CNT_W(BC_W)) u_pop (
        .bits (err_bits),
        .ones (nbits)
    );

    // Address span, sticky mask, failure count and bit statistics.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fail_count <= '0;
            addr_lo    <= '1;
            addr_hi    <= '0;
            bit_mask   <= '0;
            bits_total <= '0;
            bits_min   <= '1;
            bits_max   <= '0;
        end else if (fail) begin
            fail_count <= fail_count + 1'b1;
            if (cmp_addr < addr_lo) addr_lo <= cmp_addr;
            if (cmp_addr > addr_hi) addr_hi <= cmp_addr;
            bit_mask   <= bit_mask | err_bits;
            bits_total <= bits_total + TOT_W'(nbits);
            if (nbits < bits_min) bits_min <= nbits;
            if (nbits > bits_max) bits_max <= nbits;
        end
    end

    mel_run_track #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .cmp_valid (cmp_valid),
        .fail      (fail_live),
        .addr      (cmp_addr),
        .run_max   (run_max)
    );

    mel_record #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TEST_W(TEST_W), .CNT_W(CNT_W)) u_rec (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .fail        (fail_live),
        .test        (cmp_test),
        .addr        (cmp_addr),
        .err_bits    (err_bits),
        .last_test   (last_test),
        .last_addr   (last_addr),
        .last_bits   (last_bits),
        .last_repeat (last_repeat)
    );

    mel_test_counters #(.TEST_W(TEST_W), .CNT_W(CNT_W)) u_tcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .fail   (fail_live),
        .test   (cmp_test),
        .counts (test_counts)
    );

endmodule

// File: rtl/mem_err_logger_chk.sv
// Property checker for mem_err_logger, attached by bind below.
// Assumes a reset is applied from time zero.
module mem_err_logger_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int BC_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              cmp_valid,
    input logic [DATA_W-1:0] cmp_exp,
    input logic [DATA_W-1:0] cmp_got,
    input logic [CNT_W-1:0]  fail_count,
    input logic [ADDR_W-1:0] addr_lo,
    input logic [ADDR_W-1:0] addr_hi,
    input logic [DATA_W-1:0] bit_mask,
    input logic [BC_W-1:0]   bits_min,
    input logic [BC_W-1:0]   bits_max,
    input logic [CNT_W-1:0]  run_max,
    input logic [CNT_W-1:0]  last_repeat
);

    // A passing compare leaves the summary alone (R1).
    assert_pass_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && (cmp_exp == cmp_got) && !clr) |=> ($stable(fail_count) && $stable(bit_mask)));

    // Span is ordered once a failure exists (R2).
    assert_span_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_count != '0) |-> (addr_lo <= addr_hi));

    // Sticky mask never loses a bit without a clear (R3).
    assert_mask_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((bit_mask & $past(bit_mask)) == $past(bit_mask)));

    // Per-failure bit counts are ordered and nonzero (R4).
    assert_bits_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_count != '0) |-> ((bits_min <= bits_max) && (bits_min != '0)));

    // A run cannot be longer than the number of failures (R6).
    assert_run_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_max <= fail_count);

    // A record exists whenever failures exist (R8).
    assert_record_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((fail_count != '0) == (last_repeat != '0)) && (last_repeat <= fail_count));

    // Clear empties the summary on the next edge (R9).
    assert_clear_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((fail_count == '0) && (addr_lo == '1) && (addr_hi == '0) &&
                 (bit_mask == '0) && (run_max == '0) && (last_repeat == '0)));

    // Idle cycles change no count (R10).
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_valid && !clr) |=> $stable(fail_count));

endmodule

bind mem_err_logger mem_err_logger_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .BC_W   (BC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .cmp_valid   (cmp_valid),
    .cmp_exp     (cmp_exp),
    .cmp_got     (cmp_got),
    .fail_count  (fail_count),
    .addr_lo     (addr_lo),
    .addr_hi     (addr_hi),
    .bit_mask    (bit_mask),
    .bits_min    (bits_min),
    .bits_max    (bits_max),
    .run_max     (run_max),
    .last_repeat (last_repeat)
);

// File: tb/mem_err_logger_test.sv
// Bench for mem_err_logger: behavioural reference model, compared every cycle.
module mem_err_logger_test;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int TW = 4;
    localparam int CW = 16;
    localparam int NT = 1 << TW;
    localparam int BW = 6;
    localparam int TOTW = CW + BW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic cmp_valid = 1'b0;
    logic [TW-1:0] cmp_test = '0;
    logic [AW-1:0] cmp_addr = '0;
    logic [DW-1:0] cmp_exp = '0;
    logic [DW-1:0] cmp_got = '0;

    logic [CW-1:0]    fail_count;
    logic [AW-1:0]    addr_lo, addr_hi;
    logic [DW-1:0]    bit_mask;
    logic [TOTW-1:0]  bits_total;
    logic [BW-1:0]    bits_min, bits_max;
    logic [CW-1:0]    run_max;
    logic [NT*CW-1:0] test_counts;
    logic [TW-1:0]    last_test;
    logic [AW-1:0]    last_addr;
    logic [DW-1:0]    last_bits;
    logic [CW-1:0]    last_repeat;

    mem_err_logger uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cmp_valid(cmp_valid),
        .cmp_test(cmp_test), .cmp_addr(cmp_addr), .cmp_exp(cmp_exp), .cmp_got(cmp_got),
        .fail_count(fail_count), .addr_lo(addr_lo), .addr_hi(addr_hi),
        .bit_mask(bit_mask), .bits_total(bits_total), .bits_min(bits_min),
        .bits_max(bits_max), .run_max(run_max), .test_counts(test_counts),
        .last_test(last_test), .last_addr(last_addr), .last_bits(last_bits),
        .last_repeat(last_repeat)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference model state
    int unsigned m_cnt, m_tot, m_min, m_max, m_run, m_runmax, m_rep;
    logic [AW-1:0] m_lo, m_hi, m_prev, m_laddr;
    logic [DW-1:0] m_mask, m_lbits;
    int unsigned m_ltest;
    int unsigned m_tc [NT];

    task automatic m_init();
        m_cnt = 0; m_tot = 0; m_min = 63; m_max = 0; m_run = 0; m_runmax = 0; m_rep = 0;
        m_lo = '1; m_hi = '0; m_prev = '0; m_laddr = '0; m_mask = '0; m_lbits = '0;
        m_ltest = 0;
        for (int t = 0; t < NT; t++) m_tc[t] = 0;
    endtask

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R5", "fail_count", 64'(fail_count), 64'(m_cnt));
        check("R2", "addr_lo", 64'(addr_lo), 64'(m_lo));
        check("R2", "addr_hi", 64'(addr_hi), 64'(m_hi));
        check("R3", "bit_mask", 64'(bit_mask), 64'(m_mask));
        check("R4", "bits_total", 64'(bits_total), 64'(m_tot));
        check("R4", "bits_min", 64'(bits_min), 64'(m_min));
        check("R4", "bits_max", 64'(bits_max), 64'(m_max));
        check("R6", "run_max", 64'(run_max), 64'(m_runmax));
        for (int t = 0; t < NT; t++)
            check("R7", $sformatf("test_count[%0d]", t), 64'(test_counts[t*CW +: CW]), 64'(m_tc[t]));
        check("R8", "last_test", 64'(last_test), 64'(m_ltest));
        check("R8", "last_addr", 64'(last_addr), 64'(m_laddr));
        check("R1", "last_bits", 64'(last_bits), 64'(m_lbits));
        check("R8", "last_repeat", 64'(last_repeat), 64'(m_rep));
    endtask

    // One clock: drive at negedge, model the edge, compare at next negedge.
    task automatic step(input bit v, input int unsigned t, input logic [AW-1:0] a,
                        input logic [DW-1:0] e, input logic [DW-1:0] g, input bit c);
        logic [DW-1:0] x;
        int unsigned pc;
        cmp_valid = v; cmp_test = TW'(t); cmp_addr = a; cmp_exp = e; cmp_got = g; clr = c;
        @(posedge clk);
        x = e ^ g;
        pc = $countones(x);
        if (c) begin
            m_init();                        // R9: clear wins
        end else if (v && x != '0) begin
            m_cnt++;
            if (a < m_lo) m_lo = a;
            if (a > m_hi) m_hi = a;
            m_mask |= x;
            m_tot += pc;
            if (pc < m_min) m_min = pc;
            if (pc > m_max) m_max = pc;
            if (m_run != 0 && a == m_prev + 32'd1) m_run++; else m_run = 1;
            m_prev = a;
            if (m_run > m_runmax) m_runmax = m_run;
            m_tc[t]++;
            if (m_rep != 0 && a == m_laddr && x == m_lbits) m_rep++;
            else begin m_ltest = t; m_laddr = a; m_lbits = x; m_rep = 1; end
        end else if (v) begin
            m_run = 0;                       // R6: passing compare breaks run
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic fail_at(input int unsigned t, input logic [AW-1:0] a, input logic [DW-1:0] x);
        step(1, t, a, 32'h5A5A_0F0F, 32'h5A5A_0F0F ^ x, 0);
    endtask

    task automatic idle();
        step(0, 0, '0, '0, '0, 0);
    endtask

    task automatic do_reset();
        rst_n = 0; cmp_valid = 0; clr = 0;
        repeat (3) @(negedge clk);
        m_init();
        compare_all();                       // R9/R10 reset state
        rst_n = 1;
    endtask

    initial begin
        m_init();
        do_reset();
        idle();                              // R10: idle cycle holds reset values

        // R1: passing compare changes nothing
        step(1, 2, 32'h40, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0);

        // R2 first failure sets both bounds; R8 new record
        fail_at(3, 32'h100, 32'h0000_0001);
        // R8 identical repeat; R6 same address is not adjacent
        fail_at(3, 32'h100, 32'h0000_0001);
        // R8 same address, different pattern => new record
        fail_at(3, 32'h100, 32'h0000_0003);
        // R6 contiguous run
        fail_at(4, 32'h101, 32'h0000_0100);
        fail_at(4, 32'h102, 32'h8000_0000);
        fail_at(5, 32'h103, 32'h0000_0010);
        // R6 idle keeps run, passing compare breaks it
        idle();
        fail_at(5, 32'h104, 32'h0000_0010);
        step(1, 5, 32'h105, 32'h1, 32'h1, 0);
        fail_at(5, 32'h106, 32'h0000_0010);
        // R4 all bits flipped => popcount 32
        fail_at(15, 32'h0000_0010, 32'hFFFF_FFFF);
        fail_at(0, 32'hFFFF_FFF0, 32'h0001_0000);
        // R9 clear beats a same-cycle failure
        step(1, 7, 32'h500, 32'h0, 32'hFF, 1);
        // R2 first failure after clear sets both bounds
        fail_at(9, 32'h2000, 32'h0000_0C00);
        fail_at(9, 32'h1FFF, 32'h0000_0C00);

        // Mixed random traffic over a narrow address window (R1-R8)
        for (int i = 0; i < 600; i++) begin
            int unsigned r;
            r = $urandom_range(0, 9);
            if (r == 0) idle();
            else if (r == 1) step(1, $urandom_range(0, NT-1), $urandom_range(0, 15), 32'h77, 32'h77, 0);
            else if (r == 2 && i % 97 == 0) step(1, 1, 32'h3, 32'h0, 32'h1, 1);
            else fail_at($urandom_range(0, NT-1), 32'(($urandom_range(0, 15) + i / 8)),
                         32'(1) << $urandom_range(0, 31) | ((r > 6) ? 32'($urandom) : 32'h0));
        end

        // Reset in mid-campaign returns everything to initial values
        fail_at(2, 32'h77, 32'h3);
        do_reset();
        idle();

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule